// File: doc/BRIEF.md
# Cross-Lane Reduction Sequencer

This block steers one lane of a multi-lane vector unit through a reduction. After a reduction is launched, the lane first folds its own elements into a single partial value, one element per accepted operand. Next, the lanes merge their partials in a binary tree through a neighbour-exchange path that uses valid/ready handshakes. In each round, a lane either sends its partial and drops out, or receives one partial and merges it. When every round is done, lane 0 halves its 64-bit accumulator, merging the upper and lower sub-words, until a single element of the selected width remains. It then raises a one-cycle commit strobe.

The block produces only the control signals: an accumulator-select code, exchange valid and ready, the current fold level, and commit. The arithmetic lives in the datapath next to it. The lane index, the lane count, the element width and the element count are captured when the reduction is launched.

Top module: `lane_fold_ctrl`

## Requirements
- R1: After reset the block is idle: `acc_sel` is HOLD (0), and `tx_valid`, `rx_ready` and `commit` are low.
- R2: A launch with `is_red` low leaves the block idle. No later `op_valid`, `rx_valid` or `tx_ready` produces a non-HOLD select or any exchange or commit output.
- R3: In the local phase, each cycle with `op_valid` high consumes one element. The first element gives LOAD (1) and each later one gives ADD (2). Cycles without `op_valid` give HOLD. Exactly `elem_cnt` elements are consumed (`elem_cnt` ≥ 1).
- R4: Exchange round r runs from 0 to log2(`nr_lanes`)−1. In round r, a lane whose lowest set index bit is bit r transmits. Such a lane returns to idle after its transfer and never raises `commit`.
- R5: Once `tx_valid` is raised, it stays high until a cycle with `tx_ready` high. That cycle completes the transfer.
- R6: A lane that is receiving in a round holds `rx_ready` high. Each cycle with `rx_valid` high gives COMBINE (3) and ends that round. Lane 0 receives exactly log2(`nr_lanes`) partials.
- R7: After its last round, lane 0 gives FOLD (4) for 3−`sew` consecutive cycles, where the `sew` code 0/1/2/3 means 8/16/32/64-bit elements. During these cycles `fold_lvl` counts 0, 1, 2 and so on.
- R8: After the fold, lane 0 raises `commit` for exactly one cycle and then returns to idle. With `sew`=3 there is no fold, so `commit` follows the last round directly.
- R9: With `nr_lanes`=1, the exchange phase is skipped entirely.
- R10: `start` is ignored while a reduction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch of a new vector operation |
| is_red | input | 1 | Launched operation is a reduction |
| sew | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| elem_cnt | input | ELEM_W | Elements held by this lane (≥1) |
| lane_id | input | LID_W | Index of this lane |
| nr_lanes | input | LID_W+1 | Number of lanes, a power of two |
| op_valid | input | 1 | Source element available this cycle |
| tx_ready | input | 1 | Exchange path accepts the outgoing partial |
| rx_valid | input | 1 | Exchange path offers an incoming partial |
| acc_sel | output | 3 | Accumulator action (0 HOLD, 1 LOAD, 2 ADD, 3 COMBINE, 4 FOLD) |
| fold_lvl | output | 2 | Index of the current halving step |
| tx_valid | output | 1 | Outgoing partial is valid |
| rx_ready | output | 1 | Ready for an incoming partial |
| commit | output | 1 | Final result of lane 0 is written |

## Verification
The assertions rely on several properties of the inputs. `nr_lanes` must be a power of two no larger than the configured maximum, and `lane_id` must be below it. `elem_cnt` must be nonzero whenever a reduction is launched. The exchange path must deliver exactly one partial per receiving round. The directed stimulus drives only such configurations (1, 2 and 4 lanes, lane indices within range, counts of 1 to 3). It offers `rx_valid` only in rounds where a partial is due, and it holds `tx_ready` low for several cycles to exercise the transmit hold.

// File: rtl/lane_fold_pkg.sv
// Shared types of the cross-lane reduction sequencer.
// Assumes nothing beyond a 64-bit accumulator word.
package lane_fold_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOCAL  = 3'd1,
        PH_TX     = 3'd2,
        PH_RX     = 3'd3,
        PH_FOLD   = 3'd4,
        PH_COMMIT = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        SEL_HOLD    = 3'd0,
        SEL_LOAD    = 3'd1,
        SEL_ADD     = 3'd2,
        SEL_COMBINE = 3'd3,
        SEL_FOLD    = 3'd4
    } acc_sel_e;

endpackage

// File: rtl/lfc_step_cnt.sv
// Up-counter with synchronous clear and a last-step flag.
// Assumes limit >= 1 whenever at_last is used.
module lfc_step_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    // counts accepted steps, cleared between reductions
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (inc)        cnt <= cnt + W'(1);
    end

    // flags the step that completes the count
    always_comb at_last = (cnt == W'(limit - W'(1)));
endmodule

// File: rtl/lfc_route.sv
// Picks the phase that follows a finished local phase or exchange round.
// Assumes lane_id < 2**lg and that only lane 0 reaches round lg.
module lfc_route
    import lane_fold_pkg::*;
#(
    parameter int LID_W   = 4,
    parameter int ROUND_W = 3,
    parameter int FOLD_W  = 2
) (
    input  logic [ROUND_W-1:0] round,
    input  logic [ROUND_W-1:0] lg,
    input  logic [LID_W-1:0]   lane_id,
    input  logic [FOLD_W-1:0]  fold_steps,
    output phase_e             next_ph
);
    // tree rule: bit `round` of the index selects sender or receiver
    always_comb begin
        next_ph = PH_IDLE;
        if (round >= lg) begin
            if (lane_id == '0)
                next_ph = (fold_steps != '0) ? PH_FOLD : PH_COMMIT;
        end else if (lane_id[round[$clog2(LID_W+1)-1:0]]) begin
            next_ph = PH_TX;
        end else begin
            next_ph = PH_RX;
        end
    end
endmodule

// File: rtl/lane_fold_ctrl.sv
// Per-lane controller of a vector reduction: local accumulation, binary-tree
// exchange between lanes, sub-word fold and commit in lane 0.
// Assumes nr_lanes is a power of two <= LANES_MAX, lane_id < nr_lanes and
// elem_cnt >= 1 at launch; configuration is sampled on the launch cycle.
module lane_fold_ctrl
    import lane_fold_pkg::*;
#(
    parameter int LANES_MAX = 16,
    parameter int ELEM_W    = 8,
    parameter int WORD_W    = 64,
    localparam int LID_W    = $clog2(LANES_MAX),
    localparam int ROUND_W  = $clog2(LID_W + 1) + 1,
    localparam int MAX_FOLD = $clog2(WORD_W / 8),
    localparam int FOLD_W   = $clog2(MAX_FOLD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_red,
    input  logic [1:0]        sew,
    input  logic [ELEM_W-1:0] elem_cnt,
    input  logic [LID_W-1:0]  lane_id,
    input  logic [LID_W:0]    nr_lanes,
    input  logic              op_valid,
    input  logic              tx_ready,
    input  logic              rx_valid,
    output logic [2:0]        acc_sel,
    output logic [FOLD_W-1:0] fold_lvl,
    output logic              tx_valid,
    output logic              rx_ready,
    output logic              commit
);
    phase_e             ph_q, ph_d, route_ph;
    logic [ELEM_W-1:0]  elems_q, ecnt;
    logic [LID_W-1:0]   lane_q;
    logic [ROUND_W-1:0] lg_q, lg_d, round_q, route_round;
    logic [FOLD_W-1:0]  fsteps_q, fsteps_d;
    logic               e_last, f_last, r_last_unused;
    logic               launch, rx_hs, idle;

    assign idle   = (ph_q == PH_IDLE);
    assign launch = idle && start && is_red;
    assign rx_hs  = (ph_q == PH_RX) && rx_valid;

    // log2 of the lane count and fold depth from the element width
    always_comb begin
        lg_d = '0;
        for (int i = 0; i <= LID_W; i++)
            if (nr_lanes[i]) lg_d = ROUND_W'(i);
        fsteps_d = FOLD_W'(MAX_FOLD) - FOLD_W'(sew);
    end

    // captures the reduction configuration on launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elems_q  <= '0;
            lane_q   <= '0;
            lg_q     <= '0;
            fsteps_q <= '0;
        end else if (launch) begin
            elems_q  <= elem_cnt;
            lane_q   <= lane_id;
            lg_q     <= lg_d;
            fsteps_q <= fsteps_d;
        end
    end

    // counts consumed local elements
    lfc_step_cnt #(.W(ELEM_W)) u_elem_cnt (
        .clk(clk), .rst_n(rst_n), .clear(idle),
        .inc((ph_q == PH_LOCAL) && op_valid), .limit(elems_q),
        .cnt(ecnt), .at_last(e_last)
    );

    // counts partials received from other lanes (exchange round)
    lfc_step_cnt #(.W(ROUND_W)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .clear(idle),
        .inc(rx_hs), .limit(lg_q),
        .cnt(round_q), .at_last(r_last_unused)
    );

    // counts halving steps of the sub-word fold
    lfc_step_cnt #(.W(FOLD_W)) u_fold_cnt (
        .clk(clk), .rst_n(rst_n), .clear(idle),
        .inc(ph_q == PH_FOLD), .limit(fsteps_q),
        .cnt(fold_lvl), .at_last(f_last)
    );

    // round whose role is decided when the current phase ends
    assign route_round = (ph_q == PH_RX) ? round_q + ROUND_W'(1) : '0;

    lfc_route #(.LID_W(LID_W), .ROUND_W(ROUND_W), .FOLD_W(FOLD_W)) u_route (
        .round(route_round), .lg(lg_q), .lane_id(lane_q),
        .fold_steps(fsteps_q), .next_ph(route_ph)
    );

    // phase transitions and accumulator / handshake controls
    always_comb begin
        ph_d     = ph_q;
        acc_sel  = SEL_HOLD;
        tx_valid = 1'b0;
        rx_ready = 1'b0;
        commit   = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (launch) ph_d = PH_LOCAL;
            PH_LOCAL: if (op_valid) begin
                acc_sel = (ecnt == '0) ? SEL_LOAD : SEL_ADD;
                if (e_last) ph_d = route_ph;
            end
            PH_RX: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    acc_sel = SEL_COMBINE;
                    ph_d    = route_ph;
                end
            end
            PH_TX: begin
                tx_valid = 1'b1;
                if (tx_ready) ph_d = PH_IDLE;
            end
            PH_FOLD: begin
                acc_sel = SEL_FOLD;
                if (f_last) ph_d = PH_COMMIT;
            end
            PH_COMMIT: begin
                commit = 1'b1;
                ph_d   = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // R2: a non-reduction launch leaves the block idle
    assert_nonred_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !is_red) |=> (ph_q == PH_IDLE));
    // R5: an outgoing partial is held until accepted
    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);
    // R4: only lane 0 ever commits
    assert_commit_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (lane_q == '0));
    // R8: commit is a single-cycle strobe followed by idle
    assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!commit && idle));
    // R6: never more partials received than exchange rounds
    assert_rx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        round_q <= lg_q);
    // R4: a lane never sends and receives at once
    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));
    // R10: a launch while busy does not restart local accumulation
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && start && ph_q != PH_LOCAL) |=> (ph_q != PH_LOCAL));
endmodule

// File: tb/lane_fold_ctrl_tb.sv
module lane_fold_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LID_W = 4;

    logic       clk = 1'b0;
    logic       rst_n, start, is_red, op_valid, tx_ready, rx_valid;
    logic [1:0] sew;
    logic [7:0] elem_cnt;
    logic [LID_W-1:0] lane_id;
    logic [LID_W:0]   nr_lanes;
    logic [2:0] acc_sel;
    logic [1:0] fold_lvl;
    logic       tx_valid, rx_ready, commit;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_fold_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_red(is_red), .sew(sew),
        .elem_cnt(elem_cnt), .lane_id(lane_id), .nr_lanes(nr_lanes),
        .op_valid(op_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .acc_sel(acc_sel), .fold_lvl(fold_lvl), .tx_valid(tx_valid),
        .rx_ready(rx_ready), .commit(commit)
    );

    // compare outputs after inputs settle, then advance to next negedge
    task automatic expect_out(input string tag, input int sel, input int tx,
                              input int rx, input int cm, input int lvl);
        #1;
        n_chk++;
        if (acc_sel != sel || tx_valid != tx || rx_ready != rx || commit != cm ||
            (sel == 4 && fold_lvl != lvl)) begin
            n_fail++;
            $display("FAIL %s: sel/tx/rx/commit/lvl got %0d/%0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d/%0d",
                     tag, acc_sel, tx_valid, rx_ready, commit, fold_lvl, sel, tx, rx, cm, lvl);
        end
        @(negedge clk);
    endtask

    task automatic launch(input int lane, input int nl, input int s, input int n);
        start = 1; is_red = 1; lane_id = LID_W'(lane); nr_lanes = 5'(nl);
        sew = 2'(s); elem_cnt = 8'(n);
        expect_out("R1 idle at launch", 0, 0, 0, 0, 0);
        start = 0; lane_id = '0; nr_lanes = 5'd1; elem_cnt = 8'd0;
    endtask

    task automatic test_reset;
        expect_out("R1 reset state", 0, 0, 0, 0, 0);
    endtask

    task automatic test_nonred;
        start = 1; is_red = 0; elem_cnt = 8'd2;
        expect_out("R2 non-reduction launch", 0, 0, 0, 0, 0);
        start = 0; op_valid = 1; rx_valid = 1; tx_ready = 1;
        for (int i = 0; i < 3; i++) expect_out("R2 stays idle", 0, 0, 0, 0, 0);
        op_valid = 0; rx_valid = 0; tx_ready = 0;
    endtask

    // lane 0 of 4, 8-bit elements, 3 elements, stray launch while busy
    task automatic test_lane0_four;
        launch(0, 4, 0, 3);
        op_valid = 1; expect_out("R3 first element LOAD", 1, 0, 0, 0, 0);
        op_valid = 0; expect_out("R3 gap HOLD", 0, 0, 0, 0, 0);
        op_valid = 1; expect_out("R3 ADD", 2, 0, 0, 0, 0);
        expect_out("R3 last ADD", 2, 0, 0, 0, 0);
        op_valid = 0; rx_valid = 0; start = 1; is_red = 1; elem_cnt = 8'd5;
        expect_out("R10 busy launch ignored, R6 waiting", 0, 0, 1, 0, 0);
        start = 0; rx_valid = 1;
        expect_out("R6 round0 COMBINE", 3, 0, 1, 0, 0);
        expect_out("R6 round1 COMBINE", 3, 0, 1, 0, 0);
        rx_valid = 0;
        for (int i = 0; i < 3; i++) expect_out("R7 fold step", 4, 0, 0, 0, i);
        expect_out("R8 commit", 0, 0, 0, 1, 0);
        op_valid = 1;
        expect_out("R8 back to idle", 0, 0, 0, 0, 0);
        op_valid = 0;
    endtask

    // lane 2 of 4: receives round 0, sends round 1 with stalls
    task automatic test_lane2_four;
        launch(2, 4, 2, 1);
        op_valid = 1; expect_out("R3 single LOAD", 1, 0, 0, 0, 0);
        op_valid = 0; rx_valid = 1;
        expect_out("R4 lane2 receives round0", 3, 0, 1, 0, 0);
        rx_valid = 0; tx_ready = 0;
        expect_out("R5 tx held", 0, 1, 0, 0, 0);
        expect_out("R5 tx still held", 0, 1, 0, 0, 0);
        tx_ready = 1;
        expect_out("R4 tx accepted", 0, 1, 0, 0, 0);
        tx_ready = 0;
        expect_out("R4 idle, no commit", 0, 0, 0, 0, 0);
        expect_out("R4 idle, no commit later", 0, 0, 0, 0, 0);
    endtask

    // lane 1 of 2: sends straight after local phase
    task automatic test_lane1_two;
        launch(1, 2, 1, 2);
        op_valid = 1;
        expect_out("R3 LOAD", 1, 0, 0, 0, 0);
        expect_out("R3 ADD", 2, 0, 0, 0, 0);
        op_valid = 0; tx_ready = 1;
        expect_out("R4 lane1 sends round0", 0, 1, 0, 0, 0);
        tx_ready = 0;
        expect_out("R4 lane1 idle", 0, 0, 0, 0, 0);
    endtask

    // lane 0 of 2, 16-bit elements: two fold steps
    task automatic test_lane0_two;
        launch(0, 2, 1, 1);
        op_valid = 1; expect_out("R3 LOAD", 1, 0, 0, 0, 0);
        op_valid = 0; rx_valid = 1;
        expect_out("R6 single COMBINE", 3, 0, 1, 0, 0);
        rx_valid = 0;
        expect_out("R7 fold lvl0", 4, 0, 0, 0, 0);
        expect_out("R7 fold lvl1", 4, 0, 0, 0, 1);
        expect_out("R8 commit", 0, 0, 0, 1, 0);
        expect_out("R8 idle", 0, 0, 0, 0, 0);
    endtask

    // one lane, 64-bit elements: no exchange, no fold
    task automatic test_single_lane;
        launch(0, 1, 3, 2);
        op_valid = 1;
        expect_out("R9 LOAD", 1, 0, 0, 0, 0);
        expect_out("R9 ADD", 2, 0, 0, 0, 0);
        op_valid = 0; rx_valid = 1;
        expect_out("R9 R8 direct commit", 0, 0, 0, 1, 0);
        rx_valid = 0;
        expect_out("R9 idle", 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst_n = 0; start = 0; is_red = 0; op_valid = 0; tx_ready = 0; rx_valid = 0;
        sew = 0; elem_cnt = 0; lane_id = 0; nr_lanes = 5'd1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        test_reset();
        test_nonred();
        test_lane0_four();
        test_lane2_four();
        test_lane1_two();
        test_lane0_two();
        test_single_lane();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule